// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the bus-facing front end of an I2C target. It watches an SCL/SDA pair that has already been brought into the core clock domain. Both lines pass through a programmable glitch filter. From the filtered lines the block picks out START, repeated START and STOP conditions, shifts in address and data bytes, and compares the address phase with an own address held in 7-bit or 10-bit form. For every byte it receives it decides whether to pull SDA low in the acknowledge slot.

A data path sits behind the block and receives one-cycle event pulses: start, stop, address match with direction, byte received, and controller NACK on a read byte. The first data byte of each write transfer is not acknowledged at once. The block holds SCL low until a host writes an acknowledge decision with its valid flag set. The valid flag clears itself once the decision has been used. Four small configuration registers are written through a single-cycle write port.

Top module: `i2c_tgt_matcher`

## Requirements
- R1: After reset `scl_hold_o`, `sda_low_o`, `held_o` and every event pulse are 0, and `tgt_mode_o` is 4'b1000, because the own address resets to zero.
- R2: `tgt_mode_o` bit 0 is enable, bit 1 packet mode, bit 2 FIFO transfer and bit 3 new-target. A nonzero own address gives 4'b0111 and a zero own address gives 4'b1000. In 7-bit mode the own address is register 1 bits [6:0]; in 10-bit mode it is {register 2 bits [2:1], register 1 bits [7:0]}.
- R3: Register 0 bits [14:12] hold the debounce count N, which resets to 2. A filtered line takes a new value only after the raw line has differed from it for N+1 consecutive clocks. A shorter pulse has no effect.
- R4: With filtered SCL high, a falling SDA gives a `start_o` pulse and a rising SDA gives a `stop_o` pulse. A repeated START puts the block back into the address phase.
- R5: In 7-bit mode (register 2 bit 0 = 0), a first byte whose upper seven bits equal the own address is ACKed, and `match_o` pulses with `rd_o` equal to the byte's bit 0. Any other byte is NACKed, and nothing that follows raises an event until the next START or STOP.
- R6: In 10-bit mode (register 2 bit 0 = 1), the byte 11110,hi[1:0],0 is ACKed. A following byte equal to register 1 is then ACKed and `match_o` pulses with `rd_o`=0. Any other second byte is NACKed.
- R7: After a 10-bit write match, a repeated START with 11110,hi[1:0],1 is ACKed and `match_o` pulses with `rd_o`=1. The same byte after a STOP, with no prior match, is NACKed.
- R8: Register 3 bit 7 is the decision-valid flag and bit 6 the ACK decision. If valid is clear when the first data byte of a write has been shifted in, `held_o` rises and SCL is held low until valid is written. The byte is then ACKed when bit 6 is 1 and NACKed when bit 6 is 0.
- R9: The valid flag clears once a decision has been used, so the next transfer holds again. A decision written before the byte arrives is applied with no hold.
- R10: Every received write data byte gives `rx_valid_o` with the byte on `rx_data_o`. Write data bytes after the first are ACKed with no hold.
- R11: In a read, a controller NACK in the acknowledge slot of a byte gives one `nack_o` pulse and ends the read phase. A controller ACK lets the read continue.
- R12: With a zero own address no byte is ACKed and `match_o` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register index: 0 bus, 1 address low, 2 address high/mode, 3 acknowledge decision |
| cfg_wdata_i | input | 32 | Configuration write data |
| scl_hold_o | output | 1 | Pull SCL low (stretch) |
| sda_low_o | output | 1 | Pull SDA low (ACK) |
| tgt_mode_o | output | 4 | {new-target, FIFO transfer, packet mode, enable} |
| start_o | output | 1 | START or repeated START pulse |
| stop_o | output | 1 | STOP pulse |
| match_o | output | 1 | Own address matched pulse |
| rd_o | output | 1 | Direction of the last match, 1 = read |
| rx_valid_o | output | 1 | Write data byte received pulse |
| rx_data_o | output | 8 | Last received write data byte |
| held_o | output | 1 | First write byte waiting for a decision |
| nack_o | output | 1 | Controller NACKed a read byte |

## Verification
The bench fires SDA glitches one clock shorter than the filter window and exactly as long as it. A filter off by one would then report a START and STOP that never happened, or miss one that did. It runs two first write bytes back to back with no new decision written between them. A valid flag that failed to clear would ACK the second one without stretching, and a decision written too early would have to be honoured with no hold. The 10-bit read header is sent both after a completed 10-bit write match and after a STOP. A matcher that does not remember the earlier match, or never forgets it, gets one of the two ACK slots wrong. A mismatched address is followed by data bytes, which catches a design that keeps decoding after it has NACKed.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W + 1);
  localparam logic [1:0] REG_BUS    = 2'd0;
  localparam logic [1:0] REG_ADR_LO = 2'd1;
  localparam logic [1:0] REG_ADR_HI = 2'd2;
  localparam logic [1:0] REG_ACK    = 2'd3;
  localparam int unsigned DBC_LSB   = 12;
  localparam int unsigned ACK_BIT   = 6;
  localparam int unsigned VLD_BIT   = 7;
  localparam logic [4:0] TEN_HDR    = 5'b11110;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADR, ST_ADR2, ST_WR, ST_RD, ST_ACK, ST_HOLD, ST_RACK, ST_SKIP
  } tgt_st_e;
endpackage

// File: rtl/i2c_tgt_glitch.sv
module i2c_tgt_glitch #(
  parameter int unsigned DBC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [DBC_W-1:0] dbc_i,
  output logic             filt_o
);
  logic [DBC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= 1'b1;
    end else if (raw_i == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q == dbc_i) begin
      cnt_q  <= '0;
      filt_o <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tgt_cfg.sv
module i2c_tgt_cfg
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned CFG_DW  = 32,
  parameter int unsigned DBC_W   = 3,
  parameter int unsigned DBC_RST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              consume_i,
  output logic [DBC_W-1:0]  dbc_o,
  output logic [BYTE_W-1:0] own_lo_o,
  output logic [1:0]        own_hi_o,
  output logic              ten_o,
  output logic              ack_o,
  output logic              vld_o,
  output logic              en_o,
  output logic [3:0]        mode_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbc_o    <= DBC_W'(DBC_RST);
      own_lo_o <= '0;
      own_hi_o <= '0;
      ten_o    <= 1'b0;
      ack_o    <= 1'b0;
      vld_o    <= 1'b0;
    end else begin
      if (consume_i) vld_o <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          REG_BUS:    dbc_o <= wdata_i[DBC_LSB +: DBC_W];
          REG_ADR_LO: own_lo_o <= wdata_i[BYTE_W-1:0];
          REG_ADR_HI: begin
            ten_o    <= wdata_i[0];
            own_hi_o <= wdata_i[2:1];
          end
          default: begin
            ack_o <= wdata_i[ACK_BIT];
            vld_o <= wdata_i[VLD_BIT];
          end
        endcase
      end
    end
  end

  assign en_o   = ten_o ? |{own_hi_o, own_lo_o} : |own_lo_o[BYTE_W-2:0];
  assign mode_o = en_o ? 4'b0111 : 4'b1000;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              en_i,
  input  logic              ten_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  input  logic [1:0]        own_hi_i,
  input  logic              ack_i,
  input  logic              vld_i,
  output logic              consume_o,
  output logic              sda_low_o,
  output logic              held_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              match_o,
  output logic              rd_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              nack_o
);
  tgt_st_e st_q, ret_q;
  logic scl_q, sda_q, ten_hit_q, first_wr_q;
  logic [BIT_CNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-1:0]    sh_q;
  logic rise, fall, start_det, stop_det, byte_end;
  logic a7_hit, hdr_hit, lo_hit;

  assign rise      = scl_i & ~scl_q;
  assign fall      = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_end  = fall && (bit_cnt_q == BIT_CNT_W'(BYTE_W));

  assign a7_hit  = en_i && !ten_i && (sh_q[BYTE_W-1:1] == own_lo_i[BYTE_W-2:0]);
  assign hdr_hit = en_i && ten_i && (sh_q[7:3] == TEN_HDR) && (sh_q[2:1] == own_hi_i);
  assign lo_hit  = (sh_q == own_lo_i);
  assign held_o  = (st_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ret_q      <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      ten_hit_q  <= 1'b0;
      first_wr_q <= 1'b0;
      sda_low_o  <= 1'b0;
      consume_o  <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      match_o    <= 1'b0;
      rd_o       <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      nack_o     <= 1'b0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      consume_o  <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      match_o    <= 1'b0;
      rx_valid_o <= 1'b0;
      nack_o     <= 1'b0;
      if (stop_det) begin
        st_q      <= ST_IDLE;
        ten_hit_q <= 1'b0;
        sda_low_o <= 1'b0;
        bit_cnt_q <= '0;
        stop_o    <= 1'b1;
      end else if (start_det) begin
        st_q      <= ST_ADR;
        sda_low_o <= 1'b0;
        bit_cnt_q <= '0;
        start_o   <= 1'b1;
      end else begin
        unique case (st_q)
          ST_ADR, ST_ADR2, ST_WR, ST_RD: begin
            if (rise) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_end) begin
              bit_cnt_q <= '0;
              st_q      <= ST_SKIP;
              if (st_q == ST_ADR) begin
                if (a7_hit) begin
                  sda_low_o  <= 1'b1;
                  st_q       <= ST_ACK;
                  ret_q      <= sh_q[0] ? ST_RD : ST_WR;
                  match_o    <= 1'b1;
                  rd_o       <= sh_q[0];
                  first_wr_q <= ~sh_q[0];
                end else if (hdr_hit && !sh_q[0]) begin
                  sda_low_o <= 1'b1;
                  st_q      <= ST_ACK;
                  ret_q     <= ST_ADR2;
                  ten_hit_q <= 1'b0;
                end else if (hdr_hit && ten_hit_q) begin
                  sda_low_o <= 1'b1;
                  st_q      <= ST_ACK;
                  ret_q     <= ST_RD;
                  match_o   <= 1'b1;
                  rd_o      <= 1'b1;
                end
              end else if (st_q == ST_ADR2) begin
                if (lo_hit) begin
                  sda_low_o  <= 1'b1;
                  st_q       <= ST_ACK;
                  ret_q      <= ST_WR;
                  ten_hit_q  <= 1'b1;
                  match_o    <= 1'b1;
                  rd_o       <= 1'b0;
                  first_wr_q <= 1'b1;
                end
              end else if (st_q == ST_WR) begin
                rx_valid_o <= 1'b1;
                rx_data_o  <= sh_q;
                if (!first_wr_q) begin
                  sda_low_o <= 1'b1;
                  st_q      <= ST_ACK;
                  ret_q     <= ST_WR;
                end else begin
                  first_wr_q <= 1'b0;
                  if (vld_i) begin
                    sda_low_o <= ack_i;
                    consume_o <= 1'b1;
                    st_q      <= ST_ACK;
                    ret_q     <= ack_i ? ST_WR : ST_SKIP;
                  end else begin
                    st_q <= ST_HOLD;
                  end
                end
              end else begin
                st_q <= ST_RACK;
              end
            end
          end
          ST_HOLD: begin
            if (vld_i) begin
              sda_low_o <= ack_i;
              consume_o <= 1'b1;
              st_q      <= ST_ACK;
              ret_q     <= ack_i ? ST_WR : ST_SKIP;
            end
          end
          ST_ACK: begin
            if (fall) begin
              st_q      <= ret_q;
              sda_low_o <= 1'b0;
              bit_cnt_q <= '0;
            end
          end
          ST_RACK: begin
            if (rise && sda_i) begin
              nack_o <= 1'b1;
              st_q   <= ST_SKIP;
            end else if (fall) begin
              st_q      <= ST_RD;
              bit_cnt_q <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_matcher.sv
module i2c_tgt_matcher
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned CFG_DW  = 32,
  parameter int unsigned DBC_W   = 3,
  parameter int unsigned DBC_RST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              scl_hold_o,
  output logic              sda_low_o,
  output logic [3:0]        tgt_mode_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              match_o,
  output logic              rd_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              held_o,
  output logic              nack_o
);
  localparam int unsigned N_LINES = 2;

  logic [DBC_W-1:0]   dbc;
  logic [BYTE_W-1:0]  own_lo;
  logic [1:0]         own_hi;
  logic               ten, ack, vld, en, consume;
  logic [N_LINES-1:0] raw, filt;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_tgt_glitch #(.DBC_W(DBC_W)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .dbc_i (dbc),
      .filt_o(filt[g])
    );
  end

  i2c_tgt_cfg #(.CFG_DW(CFG_DW), .DBC_W(DBC_W), .DBC_RST(DBC_RST)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .consume_i(consume),
    .dbc_o    (dbc),
    .own_lo_o (own_lo),
    .own_hi_o (own_hi),
    .ten_o    (ten),
    .ack_o    (ack),
    .vld_o    (vld),
    .en_o     (en),
    .mode_o   (tgt_mode_o)
  );

  i2c_tgt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[0]),
    .sda_i     (filt[1]),
    .en_i      (en),
    .ten_i     (ten),
    .own_lo_i  (own_lo),
    .own_hi_i  (own_hi),
    .ack_i     (ack),
    .vld_i     (vld),
    .consume_o (consume),
    .sda_low_o (sda_low_o),
    .held_o    (held_o),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .match_o   (match_o),
    .rd_o      (rd_o),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o),
    .nack_o    (nack_o)
  );

  assign scl_hold_o = held_o;
endmodule

// File: rtl/i2c_tgt_matcher_chk.sv
module i2c_tgt_matcher_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       cfg_we_i,
  input logic [1:0] cfg_addr_i,
  input logic       vld_wr_i,
  input logic       scl_hold_o,
  input logic       sda_low_o,
  input logic       tgt_en_i,
  input logic       start_o,
  input logic       stop_o,
  input logic       match_o,
  input logic       held_o,
  input logic       nack_o
);
  AST_HOLD_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hold_o |-> !sda_low_o); // R8

  AST_RELEASE_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_o) |-> $past(cfg_we_i && (cfg_addr_i == 2'd3) && vld_wr_i, 2)); // R9

  AST_MATCH_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> tgt_en_i); // R12

  AST_START_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o)); // R4

  AST_ACK_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> (!scl_i || $past(scl_hold_o))); // R5

  AST_NACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |=> !nack_o); // R11
endmodule

bind i2c_tgt_matcher i2c_tgt_matcher_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .cfg_we_i  (cfg_we_i),
  .cfg_addr_i(cfg_addr_i),
  .vld_wr_i  (cfg_wdata_i[7]),
  .scl_hold_o(scl_hold_o),
  .sda_low_o (sda_low_o),
  .tgt_en_i  (tgt_mode_o[0]),
  .start_o   (start_o),
  .stop_o    (stop_o),
  .match_o   (match_o),
  .held_o    (held_o),
  .nack_o    (nack_o)
);

// File: tb/i2c_tgt_matcher_tb_top.sv
module i2c_tgt_matcher_tb_top;
  localparam int HALF = 10;
  localparam logic [3:0] K_START = 4'd1, K_STOP = 4'd2, K_MATCH = 4'd3,
                         K_RX = 4'd4, K_NACK = 4'd5;

  typedef struct {
    logic [3:0] k;
    logic [7:0] d;
    string      r;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_c = 1'b1, sda_c = 1'b1;
  logic scl_w, sda_w;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic scl_hold, sda_low, start_p, stop_p, match_p, rd, rx_v, held, nack_p;
  logic [3:0] mode;
  logic [7:0] rx_d;

  int checks = 0;
  int errors = 0;
  bit seen_held = 0;
  bit done = 0;
  ev_t exp_q[$];

  always #4 clk = ~clk;

  assign scl_w = scl_c & ~scl_hold;
  assign sda_w = sda_c & ~sda_low;

  i2c_tgt_matcher dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_w),
    .sda_i      (sda_w),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .cfg_wdata_i(cfg_wdata),
    .scl_hold_o (scl_hold),
    .sda_low_o  (sda_low),
    .tgt_mode_o (mode),
    .start_o    (start_p),
    .stop_o     (stop_p),
    .match_o    (match_p),
    .rd_o       (rd),
    .rx_valid_o (rx_v),
    .rx_data_o  (rx_d),
    .held_o     (held),
    .nack_o     (nack_p)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic void push(logic [3:0] k, logic [7:0] d, string r);
    ev_t e;
    e.k = k; e.d = d; e.r = r;
    exp_q.push_back(e);
  endfunction

  function automatic void got(logic [3:0] k, logic [7:0] d);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R4 unexpected event", {k, d}, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.k == k && e.d == d, e.r, {k, d}, {e.k, e.d});
    end
  endfunction

  // monitor: compares event pulses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (start_p) got(K_START, 8'h0);
      if (match_p) got(K_MATCH, {7'h0, rd});
      if (rx_v)    got(K_RX, rx_d);
      if (nack_p)  got(K_NACK, 8'h0);
      if (stop_p)  got(K_STOP, 8'h0);
      if (held)    seen_held = 1;
    end
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic scl_pulse(output bit s);
    scl_c = 1'b1;
    while (!scl_w) @(negedge clk);
    wclk(HALF / 2);
    s = sda_w;
    wclk(HALF / 2);
    scl_c = 1'b0;
    wclk(2);
  endtask

  task automatic bus_start(string r);
    push(K_START, 8'h0, r);
    sda_c = 1'b1; wclk(HALF);
    scl_c = 1'b1; wclk(HALF);
    sda_c = 1'b0; wclk(HALF);
    scl_c = 1'b0; wclk(2);
  endtask

  task automatic bus_stop(string r);
    push(K_STOP, 8'h0, r);
    sda_c = 1'b0; wclk(HALF);
    scl_c = 1'b1; wclk(HALF);
    sda_c = 1'b1; wclk(HALF);
  endtask

  task automatic wr_byte(logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      sda_c = b[i]; wclk(HALF);
      scl_pulse(s);
    end
    sda_c = 1'b1; wclk(HALF);
    scl_pulse(ack);
  endtask

  task automatic rd_byte(bit cack);
    bit s;
    sda_c = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wclk(HALF);
      scl_pulse(s);
    end
    sda_c = ~cack; wclk(HALF);
    scl_pulse(s);
    sda_c = 1'b1;
  endtask

  task automatic wr_exp(logic [7:0] b, bit exp_ack, string r);
    bit a;
    wr_byte(b, a);
    chk(a == ~exp_ack, r, a, ~exp_ack);
  endtask

  task automatic held_write(logic [7:0] b, logic [31:0] dec, bit exp_ack, string r);
    bit a;
    fork
      wr_byte(b, a);
      begin
        int n = 0;
        while (!held && n < 400) begin @(negedge clk); n++; end
        chk(held == 1'b1, {r, " held"}, held, 1);
        wclk(30);
        chk(scl_w == 1'b0 && scl_hold == 1'b1, {r, " scl stretched"}, scl_w, 0);
        cfg_wr(2'd3, dec);
      end
    join
    chk(a == ~exp_ack, {r, " ack"}, a, ~exp_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    // R1 reset state
    chk(mode == 4'b1000, "R1 mode", mode, 4'b1000);
    chk({scl_hold, sda_low, held} == 3'b000, "R1 lines", {scl_hold, sda_low, held}, 0);
    chk({start_p, stop_p, match_p, rx_v, nack_p} == 5'b0, "R1 pulses",
        {start_p, stop_p, match_p, rx_v, nack_p}, 0);

    // R12 zero address never ACKs
    bus_start("R4 start");
    wr_exp(8'h00, 1'b0, "R12 zero addr nack");
    bus_stop("R4 stop");

    // R2 address programming, 7-bit own address 0x2A (8-bit form 0x54)
    cfg_wr(2'd1, 32'h2A);
    cfg_wr(2'd2, 32'h0);
    wclk(1);
    chk(mode == 4'b0111, "R2 mode enabled", mode, 4'b0111);

    // R3 debounce: 2-clock glitch ignored, 3-clock pulse seen (default count 2)
    wclk(5);
    sda_c = 1'b0; wclk(2); sda_c = 1'b1; wclk(10);
    chk(exp_q.size() == 0, "R3 short glitch", exp_q.size(), 0);
    push(K_START, 8'h0, "R3 start from long pulse");
    push(K_STOP, 8'h0, "R3 stop from long pulse");
    sda_c = 1'b0; wclk(3); sda_c = 1'b1; wclk(10);
    chk(exp_q.size() == 0, "R3 long pulse seen", exp_q.size(), 0);
    cfg_wr(2'd0, 32'h0);
    push(K_START, 8'h0, "R3 count 0 start");
    push(K_STOP, 8'h0, "R3 count 0 stop");
    sda_c = 1'b0; wclk(1); sda_c = 1'b1; wclk(10);
    chk(exp_q.size() == 0, "R3 count 0 one clock", exp_q.size(), 0);
    cfg_wr(2'd0, 32'h2 << 12);

    // R5 R8 R10 7-bit write with held first byte
    bus_start("R4 start");
    push(K_MATCH, 8'h0, "R5 match write");
    wr_exp(8'h54, 1'b1, "R5 addr ack");
    push(K_RX, 8'hA5, "R10 rx first");
    held_write(8'hA5, 32'hC0, 1'b1, "R8");
    push(K_RX, 8'h3C, "R10 rx second");
    seen_held = 0;
    wr_exp(8'h3C, 1'b1, "R10 auto ack");
    chk(seen_held == 0, "R10 no hold", seen_held, 0);
    bus_stop("R4 stop");

    // R9 valid cleared, so hold again; decision NACK
    bus_start("R4 start");
    push(K_MATCH, 8'h0, "R5 match write");
    wr_exp(8'h54, 1'b1, "R5 addr ack");
    push(K_RX, 8'h11, "R9 rx");
    held_write(8'h11, 32'h80, 1'b0, "R9 rehold nack");
    bus_stop("R4 stop");

    // R9 preset decision: no stretch
    cfg_wr(2'd3, 32'hC0);
    bus_start("R4 start");
    push(K_MATCH, 8'h0, "R5 match write");
    wr_exp(8'h54, 1'b1, "R5 addr ack");
    push(K_RX, 8'h22, "R9 rx preset");
    seen_held = 0;
    wr_exp(8'h22, 1'b1, "R9 preset ack");
    chk(seen_held == 0, "R9 preset no hold", seen_held, 0);
    bus_stop("R4 stop");

    // R5 mismatch ignored
    bus_start("R4 start");
    wr_exp(8'h56, 1'b0, "R5 mismatch nack");
    wr_exp(8'h77, 1'b0, "R5 ignored data");
    bus_stop("R4 stop");

    // R11 read: controller ACK then NACK
    bus_start("R4 start");
    push(K_MATCH, 8'h1, "R5 match read");
    wr_exp(8'h55, 1'b1, "R5 read addr ack");
    rd_byte(1'b1);
    push(K_NACK, 8'h0, "R11 nack pulse");
    rd_byte(1'b0);
    wclk(HALF);
    chk(sda_low == 1'b0, "R11 released after nack", sda_low, 0);
    bus_stop("R4 stop");

    // R4 repeated START restarts address phase
    bus_start("R4 start");
    push(K_MATCH, 8'h0, "R4 first match");
    wr_exp(8'h54, 1'b1, "R4 addr ack");
    bus_start("R4 repeated start");
    push(K_MATCH, 8'h1, "R4 rematch read");
    wr_exp(8'h55, 1'b1, "R4 reread ack");
    push(K_NACK, 8'h0, "R11 nack pulse");
    rd_byte(1'b0);
    bus_stop("R4 stop");

    // R6 R7 10-bit own address 0x29C
    cfg_wr(2'd1, 32'h9C);
    cfg_wr(2'd2, 32'h5);
    cfg_wr(2'd3, 32'hC0);
    wclk(1);
    chk(mode == 4'b0111, "R2 ten-bit mode", mode, 4'b0111);
    bus_start("R4 start");
    wr_exp(8'hF4, 1'b1, "R6 header ack");
    push(K_MATCH, 8'h0, "R6 match");
    wr_exp(8'h9C, 1'b1, "R6 low ack");
    push(K_RX, 8'h5A, "R6 rx");
    wr_exp(8'h5A, 1'b1, "R6 data ack");
    bus_start("R4 repeated start");
    push(K_MATCH, 8'h1, "R7 match read");
    wr_exp(8'hF5, 1'b1, "R7 read header ack");
    push(K_NACK, 8'h0, "R11 nack pulse");
    rd_byte(1'b0);
    bus_stop("R4 stop");

    bus_start("R4 start");
    wr_exp(8'hF5, 1'b0, "R7 read without match nack");
    bus_stop("R4 stop");

    bus_start("R4 start");
    wr_exp(8'hF4, 1'b1, "R6 header ack");
    wr_exp(8'h9D, 1'b0, "R6 wrong low nack");
    bus_stop("R4 stop");

    wclk(10);
    chk(exp_q.size() == 0, "R4 all events seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule